// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits on the device side of an SDRAM and works out which column each burst beat touches. A mode-register write sets the burst length and the burst order. Each read or write command then starts a burst at a given column. After that, the block steps the column address once per clock until the burst completes or something cuts it short.

A burst can end early in three ways: a burst-stop strobe, a precharge, or a fresh column command. For reads, a data-valid window follows the live beats, delayed by the programmed CAS latency. When a burst is started with auto-precharge, it cannot be interrupted. A column command or precharge that arrives during such a burst is dropped and reported on an illegal-request strobe.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, burstActive, colAddr, readValid, wrAccept and illegalReq are all 0, and the mode is burst length 1 in sequential order.
- R2: Mode bits [2:0] set the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page. The reserved codes 100, 101 and 110 behave as length 1. burstActive is 1 for exactly that many cycles, beginning the cycle after the command.
- R3: With mode bit [3] = 0, the order is sequential. The beat i address is the start column with its low log2(length) bits replaced by (start + i) modulo the length. The upper bits stay fixed.
- R4: With mode bit [3] = 1 and a length of 4 or 8, the beat i address is the start column with its low bits XORed with i. For lengths 1 and 2 and for full page, bit [3] has no effect on the order.
- R5: A full-page burst steps through all 256 columns, wraps from 255 to 0, and continues until it is terminated.
- R6: A column command is accepted on any cycle. Its start column appears on colAddr in the next cycle, which replaces any running burst. It wins over a burst stop or precharge issued in the same cycle.
- R7: A burst stop ends the burst: burstActive and colAddr read 0 from the next cycle.
- R8: A precharge during a burst without auto-precharge ends the burst in the same way as a burst stop.
- R9: readValid follows the live read beats, delayed by 2 cycles (casLat3 = 0) or 3 cycles (casLat3 = 1). A beat in a burst-stop or precharge cycle is not live, so data remains valid for 1 (CL2) or 2 (CL3) cycles after that cycle.
- R10: wrAccept is 1 on each live write beat. It goes to 0 in the same cycle that a burst stop is applied.
- R11: During an auto-precharge burst, a column command or precharge is ignored: the address sequence continues unchanged. illegalReq pulses in the following cycle.
- R12: A mode-register load during a burst leaves the running burst's length and order unchanged. The new mode applies to the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeLoad | input | 1 | Mode-register write strobe |
| modeAddr | input | 4 | Mode bits: [3] order, [2:0] length code |
| rdCmd | input | 1 | Read command strobe |
| wrCmd | input | 1 | Write command strobe |
| startCol | input | 8 | Start column of the command |
| autoPre | input | 1 | Command carries auto-precharge |
| burstStop | input | 1 | Burst-stop strobe |
| prechg | input | 1 | Precharge strobe for this bank |
| casLat3 | input | 1 | CAS latency: 0 = 2, 1 = 3 |
| colAddr | output | 8 | Column of the current beat, 0 when idle |
| burstActive | output | 1 | A burst beat is in progress |
| readValid | output | 1 | Read data window on the data pins |
| wrAccept | output | 1 | Write data accepted this cycle |
| illegalReq | output | 1 | An interrupt of an auto-precharge burst was refused |

## Verification
The two events that most easily coincide are the natural last beat of a burst and a new column command. The bench places a read command exactly on the final beat of a length-2 burst. It then judges that the next burst's start column follows with no gap in colAddr and no gap in readValid. A second coincidence is also provoked: a burst stop and a new command in the same cycle. The bench confirms that the new burst starts and runs its full length.

// File: rtl/colseq_pkg.sv
package colseq_pkg;
  localparam int COL_W = 8;
  localparam int MAX_CL = 3;

  localparam logic [2:0] LEN_CODE_1    = 3'b000;
  localparam logic [2:0] LEN_CODE_2    = 3'b001;
  localparam logic [2:0] LEN_CODE_4    = 3'b010;
  localparam logic [2:0] LEN_CODE_8    = 3'b011;
  localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

  typedef struct packed {
    logic             start;
    logic             advance;
    logic [COL_W-1:0] mask;
    logic             ilv;
  } dpStrobe_t;
endpackage

// File: rtl/colseq_dp.sv
module colseq_dp
  import colseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        stb,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] beatAddr,
  output logic             lastBeat
);
  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] maskR;
  logic             ilvR;
  logic [COL_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseCol <= '0;
      beatCnt <= '0;
      maskR   <= '0;
      ilvR    <= 1'b0;
    end else if (stb.start) begin
      baseCol <= startCol;
      beatCnt <= '0;
      maskR   <= stb.mask;
      ilvR    <= stb.ilv;
    end else if (stb.advance) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  // low bits walk inside the burst boundary, upper bits held
  always_comb begin
    lowBits  = ilvR ? (baseCol ^ beatCnt) : (baseCol + beatCnt);
    beatAddr = (baseCol & ~maskR) | (lowBits & maskR);
    lastBeat = (beatCnt == maskR);
  end
endmodule

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
  import colseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       modeLoad,
  input  logic [3:0] modeAddr,
  input  logic       rdCmd,
  input  logic       wrCmd,
  input  logic       autoPre,
  input  logic       burstStop,
  input  logic       prechg,
  input  logic       casLat3,
  input  logic       lastBeat,
  output dpStrobe_t  stb,
  output logic       burstActive,
  output logic       readValid,
  output logic       wrAccept,
  output logic       illegalReq
);
  logic [2:0]        lenCode;
  logic              ilvMode;
  logic [COL_W-1:0]  modeMask;
  logic              modeFull;
  logic              modeIlv;
  logic              active, isRead, apFlag, fullRun;
  logic              lock, anyCmd, takeCmd, cutNow, endNow, beatLive;
  logic [MAX_CL-1:0] rdPipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lenCode <= LEN_CODE_1;
      ilvMode <= 1'b0;
    end else if (modeLoad) begin
      ilvMode <= modeAddr[3];
      lenCode <= modeAddr[2:0];
    end
  end

  always_comb begin
    case (lenCode)
      LEN_CODE_2:    modeMask = COL_W'(1);
      LEN_CODE_4:    modeMask = COL_W'(3);
      LEN_CODE_8:    modeMask = COL_W'(7);
      LEN_CODE_PAGE: modeMask = '1;
      default:       modeMask = '0;
    endcase
    modeFull = (lenCode == LEN_CODE_PAGE);
    modeIlv  = ilvMode & ((lenCode == LEN_CODE_4) | (lenCode == LEN_CODE_8));
  end

  always_comb begin
    lock     = active & apFlag;
    anyCmd   = rdCmd | wrCmd;
    takeCmd  = anyCmd & ~lock;
    cutNow   = active & (burstStop | (prechg & ~lock));
    endNow   = active & lastBeat & ~fullRun;
    beatLive = active & ~cutNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      isRead     <= 1'b0;
      apFlag     <= 1'b0;
      fullRun    <= 1'b0;
      illegalReq <= 1'b0;
      rdPipe     <= '0;
    end else begin
      if (takeCmd) begin
        active  <= 1'b1;
        isRead  <= rdCmd;
        apFlag  <= autoPre;
        fullRun <= modeFull;
      end else if (cutNow || endNow) begin
        active  <= 1'b0;
      end
      illegalReq <= lock & (anyCmd | prechg);
      rdPipe     <= {rdPipe[MAX_CL-2:0], beatLive & isRead};
    end
  end

  always_comb begin
    stb.start   = takeCmd;
    stb.advance = active;
    stb.mask    = modeMask;
    stb.ilv     = modeIlv;
    burstActive = active;
    wrAccept    = beatLive & ~isRead;
    readValid   = casLat3 ? rdPipe[MAX_CL-1] : rdPipe[MAX_CL-2];
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import colseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modeLoad,
  input  logic [3:0]       modeAddr,
  input  logic             rdCmd,
  input  logic             wrCmd,
  input  logic [COL_W-1:0] startCol,
  input  logic             autoPre,
  input  logic             burstStop,
  input  logic             prechg,
  input  logic             casLat3,
  output logic [COL_W-1:0] colAddr,
  output logic             burstActive,
  output logic             readValid,
  output logic             wrAccept,
  output logic             illegalReq
);
  dpStrobe_t        stb;
  logic [COL_W-1:0] beatAddr;
  logic             lastBeat;

  colseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeLoad(modeLoad), .modeAddr(modeAddr),
    .rdCmd(rdCmd), .wrCmd(wrCmd), .autoPre(autoPre), .burstStop(burstStop),
    .prechg(prechg), .casLat3(casLat3), .lastBeat(lastBeat), .stb(stb),
    .burstActive(burstActive), .readValid(readValid), .wrAccept(wrAccept),
    .illegalReq(illegalReq)
  );

  colseq_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .startCol(startCol),
    .beatAddr(beatAddr), .lastBeat(lastBeat)
  );

  assign colAddr = burstActive ? beatAddr : '0;
endmodule

// File: rtl/colseq_chk.sv
module colseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rdCmd,
  input logic       wrCmd,
  input logic [7:0] startCol,
  input logic       burstStop,
  input logic       prechg,
  input logic       casLat3,
  input logic [7:0] colAddr,
  input logic       burstActive,
  input logic       readValid,
  input logic       illegalReq
);
  assert_cmd_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdCmd && !burstActive) |=> (burstActive && colAddr == $past(startCol)));

  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (burstActive && burstStop && !rdCmd && !wrCmd) |=> !burstActive);

  assert_prechg_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burstActive && prechg && !rdCmd && !wrCmd) |=> (!burstActive || illegalReq));

  assert_valid_cl2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (readValid && !casLat3) |-> $past(burstActive, 2));

  assert_valid_cl3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (readValid && casLat3) |-> $past(burstActive, 3));

  assert_refusal_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegalReq |-> ($past(burstActive) && $past(rdCmd || wrCmd || prechg)));
endmodule

bind sdram_col_seq colseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdCmd(rdCmd), .wrCmd(wrCmd), .startCol(startCol),
  .burstStop(burstStop), .prechg(prechg), .casLat3(casLat3), .colAddr(colAddr),
  .burstActive(burstActive), .readValid(readValid), .illegalReq(illegalReq)
);

// File: tb/sdram_col_seq_test.sv
module sdram_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       modeLoad = 1'b0;
  logic [3:0] modeAddr = '0;
  logic       rdCmd = 1'b0, wrCmd = 1'b0;
  logic [7:0] startCol = '0;
  logic       autoPre = 1'b0, burstStop = 1'b0, prechg = 1'b0, casLat3 = 1'b0;
  logic [7:0] colAddr;
  logic       burstActive, readValid, wrAccept, illegalReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdram_col_seq uut (
    .clk(clk), .rst_n(rst_n), .modeLoad(modeLoad), .modeAddr(modeAddr),
    .rdCmd(rdCmd), .wrCmd(wrCmd), .startCol(startCol), .autoPre(autoPre),
    .burstStop(burstStop), .prechg(prechg), .casLat3(casLat3),
    .colAddr(colAddr), .burstActive(burstActive), .readValid(readValid),
    .wrAccept(wrAccept), .illegalReq(illegalReq)
  );

  localparam int NV = 10;
  localparam logic [3:0] V_MODE [NV] = '{4'b0000, 4'b0001, 4'b1001, 4'b0010, 4'b1010,
                                         4'b0011, 4'b1011, 4'b0100, 4'b1110, 4'b0011};
  localparam logic [7:0] V_COL [NV]  = '{8'h25, 8'h25, 8'h25, 8'h4D, 8'h4D,
                                         8'h9B, 8'h9B, 8'h77, 8'h11, 8'hF8};
  localparam int V_LEN [NV]          = '{1, 2, 2, 4, 4, 8, 8, 1, 1, 8};
  // first beat in the low byte
  localparam logic [63:0] V_EXP [NV] = '{
    64'h25,
    64'h2425,
    64'h2425,
    64'h4C4F4E4D,
    64'h4E4F4C4D,
    64'h9A99989F9E9D9C9B,
    64'h9C9D9E9F98999A9B,
    64'h77,
    64'h11,
    64'hFFFEFDFCFBFAF9F8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic loadMode(input logic [3:0] m);
    modeAddr = m;
    modeLoad = 1'b1;
    cyc();
    modeLoad = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 active in reset", burstActive, 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 burstActive", burstActive, 0);
    chk("R1 colAddr", colAddr, 0);
    chk("R1 readValid", readValid, 0);
    chk("R1 wrAccept", wrAccept, 0);
    chk("R1 illegalReq", illegalReq, 0);
    // default mode is length 1
    startCol = 8'h33; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    chk("R1 default beat", colAddr, 8'h33);
    cyc();
    chk("R1 default length 1", burstActive, 0);
    idle(4);

    // table of lengths and orders (R2 R3 R4)
    for (int v = 0; v < NV; v++) begin
      loadMode(V_MODE[v]);
      startCol = V_COL[v]; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
      for (int b = 0; b < V_LEN[v]; b++) begin
        chk($sformatf("R3 R4 vector %0d beat %0d", v, b), colAddr, 32'(V_EXP[v][b*8 +: 8]));
        chk($sformatf("R2 vector %0d active beat %0d", v, b), burstActive, 1);
        cyc();
      end
      chk($sformatf("R2 vector %0d end", v), burstActive, 0);
      idle(4);
    end

    // R5 full page wrap, then R7 stop
    loadMode(4'b0111);
    startCol = 8'hFE; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    for (int i = 0; i < 260; i++) begin
      chk("R5 page beat", colAddr, 32'((8'hFE + i) & 8'hFF));
      if (i < 259) cyc();
    end
    chk("R5 still active", burstActive, 1);
    burstStop = 1'b1; cyc(); burstStop = 1'b0;
    chk("R7 stop ends", burstActive, 0);
    chk("R7 addr zero", colAddr, 0);
    idle(4);

    // R4 full page ignores interleave bit
    loadMode(4'b1111);
    startCol = 8'h05; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R4 page sequential", colAddr, 32'(8'h05 + i));
      cyc();
    end
    burstStop = 1'b1; cyc(); burstStop = 1'b0;
    idle(4);

    // R9 CL3 full BL4 read window
    loadMode(4'b0010);
    casLat3 = 1'b1;
    startCol = 8'h00; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    for (int s = 1; s <= 8; s++) begin
      chk($sformatf("R9 CL3 window sample %0d", s), readValid, (s >= 4 && s <= 7) ? 1 : 0);
      cyc();
    end
    idle(3);

    // R9 CL3 burst stop: two valid cycles after stop cycle
    loadMode(4'b0011);
    startCol = 8'h40; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    cyc(); cyc();
    burstStop = 1'b1;
    chk("R9 CL3 not yet valid", readValid, 0);
    cyc(); burstStop = 1'b0;
    chk("R9 CL3 after stop 1", readValid, 1);
    chk("R7 read stop ends", burstActive, 0);
    cyc();
    chk("R9 CL3 after stop 2", readValid, 1);
    cyc();
    chk("R9 CL3 window closed", readValid, 0);
    idle(4);

    // R9 CL2 burst stop: one valid cycle after stop cycle
    casLat3 = 1'b0;
    startCol = 8'h40; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    cyc(); cyc();
    burstStop = 1'b1;
    chk("R9 CL2 stop cycle valid", readValid, 1);
    cyc(); burstStop = 1'b0;
    chk("R9 CL2 after stop", readValid, 1);
    cyc();
    chk("R9 CL2 window closed", readValid, 0);
    idle(4);

    // R10 write stop cuts acceptance at once
    loadMode(4'b0010);
    startCol = 8'h10; wrCmd = 1'b1; cyc(); wrCmd = 1'b0;
    chk("R10 write beat", wrAccept, 1);
    chk("R10 write addr", colAddr, 8'h10);
    burstStop = 1'b1; #1;
    chk("R10 stop drops accept", wrAccept, 0);
    chk("R10 still active in stop cycle", burstActive, 1);
    cyc(); burstStop = 1'b0;
    chk("R10 write ended", burstActive, 0);
    chk("R10 no read window", readValid, 0);
    idle(4);

    // R8 precharge ends plain burst
    loadMode(4'b0011);
    startCol = 8'h40; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    chk("R8 beat0", colAddr, 8'h40);
    cyc();
    chk("R8 beat1", colAddr, 8'h41);
    prechg = 1'b1; cyc(); prechg = 1'b0;
    chk("R8 precharge ends", burstActive, 0);
    chk("R8 no refusal", illegalReq, 0);
    idle(4);

    // R11 auto-precharge burst refuses interrupts
    loadMode(4'b0010);
    startCol = 8'h20; autoPre = 1'b1; rdCmd = 1'b1; cyc(); autoPre = 1'b0;
    chk("R11 beat0", colAddr, 8'h20);
    startCol = 8'h80;
    cyc(); rdCmd = 1'b0;
    chk("R11 cmd ignored", colAddr, 8'h21);
    chk("R11 cmd flagged", illegalReq, 1);
    prechg = 1'b1; cyc(); prechg = 1'b0;
    chk("R11 precharge ignored", colAddr, 8'h22);
    chk("R11 precharge flagged", illegalReq, 1);
    chk("R11 still active", burstActive, 1);
    cyc();
    chk("R11 last beat", colAddr, 8'h23);
    chk("R11 flag clears", illegalReq, 0);
    cyc();
    chk("R11 ends normally", burstActive, 0);
    idle(4);

    // R6 back to back, command beats a same-cycle stop
    startCol = 8'h10; rdCmd = 1'b1; cyc();
    chk("R6 first", colAddr, 8'h10);
    startCol = 8'h31; cyc();
    chk("R6 second replaces", colAddr, 8'h31);
    startCol = 8'h52; burstStop = 1'b1; cyc(); rdCmd = 1'b0; burstStop = 1'b0;
    chk("R6 cmd wins over stop", colAddr, 8'h52);
    cyc();
    chk("R6 run beat1", colAddr, 8'h53);
    cyc();
    chk("R6 run beat2", colAddr, 8'h50);
    cyc();
    chk("R6 run beat3", colAddr, 8'h51);
    cyc();
    chk("R6 run ends", burstActive, 0);
    idle(4);

    // R6 command on the natural last beat, seamless with CL2 window
    loadMode(4'b0001);
    startCol = 8'h08; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    chk("R6 seam beat0", colAddr, 8'h08);
    cyc();
    chk("R6 seam last beat", colAddr, 8'h09);
    chk("R9 seam before window", readValid, 0);
    startCol = 8'h0A; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    chk("R6 seam next start", colAddr, 8'h0A);
    chk("R9 seam valid 1", readValid, 1);
    cyc();
    chk("R6 seam next beat", colAddr, 8'h0B);
    chk("R9 seam valid 2", readValid, 1);
    cyc();
    chk("R6 seam ended", burstActive, 0);
    chk("R9 seam valid 3", readValid, 1);
    cyc();
    chk("R9 seam valid 4", readValid, 1);
    cyc();
    chk("R9 seam closed", readValid, 0);
    idle(4);

    // R12 mode load mid-burst does not alter it
    loadMode(4'b0010);
    startCol = 8'h00; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    modeAddr = 4'b0011; modeLoad = 1'b1; cyc(); modeLoad = 1'b0;
    chk("R12 beat1 unchanged", colAddr, 8'h01);
    cyc(); cyc();
    chk("R12 beat3", colAddr, 8'h03);
    cyc();
    chk("R12 old length kept", burstActive, 0);
    startCol = 8'h00; rdCmd = 1'b1; cyc(); rdCmd = 1'b0;
    idle(7);
    chk("R12 new length active", burstActive, 1);
    chk("R12 new length beat7", colAddr, 8'h07);
    cyc();
    chk("R12 new length ends", burstActive, 0);
    idle(4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule